// File: doc/BRIEF.md
# Memory-Space Task-File and Data-Port Decoder

This block sits between a host that uses memory cycles and the register file of a storage card. Each access carries an 11-bit address, a register-space select, two active-low byte-lane enables and active-low read and write strobes. The block decodes the access. It sends the access either to one of the byte-wide task-file registers or to a sector buffer that the host can only reach through a sequential data port. Word transfers and byte transfers share that port. A small phase tracker keeps the low byte and the high byte of each buffer word in the right order. This holds whichever data offset the host uses: the main data offset, its duplicates, or the 1 KB upper window.

The read path is combinational from the live address while the read strobe is low. Every state change is committed when a strobe is released. The strobes are first synchronised to the internal clock. Address, enables and write data are captured while the synchronised strobe is low. The sector buffer is an internal word memory behind a wrapping word pointer. A command write rewinds the pointer.

Top module: `mm_taskfile_port`

## Requirements
- R1: After reset every task-file output register is zero, cmd_strobe is low, the buffer pointer is at word 0 with the byte phase at the low byte, and rdata is zero while oe_n is high.
- R2: With reg_n high and addr[10] low, addr[3:0] selects the offset and addr[9:4] have no effect. With reg_n low an access changes no state and reads return zero.
- R3: Offsets 2, 3, 4, 5 and 6 are read/write registers (count, sector, cylinder low, cylinder high, select). Offsets 1 and D read err_in and write features. Offset 7 reads status_in, and a write to it loads cmd_code and pulses cmd_strobe for one cycle. Offset E reads status_in and writes device control. Offset F reads drive_in, and writes to it change nothing. A register byte uses D7..D0 when ce1_n is low and D15..D8 when ce1_n is high and ce2_n is low.
- R4: At offset 0, a byte access with ce1_n high and ce2_n low reaches the error/features register on D15..D8. It leaves the buffer and the pointer untouched.
- R5: A word access (both enables low) to offset 0, 8 or 9 moves one 16-bit buffer word and advances the pointer by one, so repeated word accesses stream consecutive words.
- R6: Byte accesses with ce1_n low to offset 0 or 8 alternate between the low byte and the high byte of the current word, starting with the low byte, on D7..D0. The pointer advances after the second byte of each pair.
- R7: A byte access to offset 9 moves only the high byte of the current word. An access to 8 followed by one to 9 takes the low then the high byte and advances. An access to 9 followed by one to 8 takes the high then the low byte of the same word, then advances.
- R8: Two byte accesses in a row to offset 9 both move the high byte of the same word, and the pointer advances after the second one.
- R9: With addr[10] high, any even address acts as offset 8 and any odd address as offset 9, so incrementing byte addresses stream consecutive buffer bytes.
- R10: A write to offset 7 rewinds the pointer to word 0 and resets the byte phase to the low byte.
- R11: A write or a pointer step takes effect only after the strobe is released, and uses the address, enables and data held while the strobe was low. A byte read places the byte on D15..D8 when ce1_n is high, and on D7..D0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_n | input | 1 | High selects the common-memory register space |
| addr | input | 11 | Host byte address |
| ce1_n | input | 1 | Low-lane enable, active low |
| ce2_n | input | 1 | High-lane enable, active low |
| oe_n | input | 1 | Read strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Host read data, zero when no read is active |
| err_in | input | 8 | Error byte returned at offsets 1 and D |
| status_in | input | 8 | Status byte returned at offsets 7 and E |
| drive_in | input | 8 | Drive address byte returned at offset F |
| tf_features | output | 8 | Features register |
| tf_count | output | 8 | Sector count register |
| tf_sector | output | 8 | Sector number register |
| tf_cyl_lo | output | 8 | Cylinder low register |
| tf_cyl_hi | output | 8 | Cylinder high register |
| tf_select | output | 8 | Card/head select register |
| tf_devctl | output | 8 | Device control register |
| cmd_code | output | 8 | Last command byte written |
| cmd_strobe | output | 1 | One-cycle pulse per command write |

## Verification
The data port is driven with word streams through offsets 0, 8 and 9 and with byte streams through offset 8 alone. It is also driven with alternating 8/9 and 9/8 byte pairs, with repeated 9 accesses, and with incrementing addresses in the upper window. Each pattern has its own expected byte sequence, so a swapped lane, a missed pointer step or an extra pointer step shows up as a wrong byte at a known position. Task-file accesses are repeated on both byte lanes and with junk in the ignored address bits. Odd-lane writes to offset 0, writes to the drive address, and accesses with register space deselected are each followed by read-backs. These read-backs show that those accesses left the registers and the buffer pointer unchanged.

// File: rtl/mm_tf_pkg.sv
package mm_tf_pkg;

  typedef enum logic [1:0] {
    LANE_NONE,
    LANE_WORD,
    LANE_LO,
    LANE_HI
  } lane_e;

  typedef enum logic [3:0] {
    T_NONE,
    T_DATA_WORD,
    T_DATA_BYTE,
    T_DATA_ODD,
    T_ERRFEAT,
    T_COUNT,
    T_SECTOR,
    T_CYL_LO,
    T_CYL_HI,
    T_SELECT,
    T_STATCMD,
    T_ALTCTL,
    T_DRVADDR
  } tgt_e;

  typedef enum logic [1:0] {
    PH_NONE,
    PH_LO_DONE,
    PH_HI_DONE
  } phase_e;

  typedef struct packed {
    tgt_e  tgt;
    lane_e lane;
  } acc_t;

endpackage

// File: rtl/mm_tf_decode.sv
module mm_tf_decode
  import mm_tf_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              reg_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce1_n,
  input  logic              ce2_n,
  output acc_t              acc
);
  localparam int WIN_BIT = ADDR_W - 1;

  logic [3:0] off;
  lane_e      lane;
  tgt_e       tgt;

  always_comb begin
    unique case ({ce1_n, ce2_n})
      2'b00:   lane = LANE_WORD;
      2'b01:   lane = LANE_LO;
      2'b10:   lane = LANE_HI;
      default: lane = LANE_NONE;
    endcase

    // upper window folds onto the two data offsets by address parity
    off = addr[WIN_BIT] ? {3'b100, addr[0]} : addr[3:0];

    tgt = T_NONE;
    case (off)
      4'h0: tgt = (lane == LANE_WORD) ? T_DATA_WORD :
                  (lane == LANE_LO)   ? T_DATA_BYTE : T_ERRFEAT;
      4'h8: tgt = (lane == LANE_WORD) ? T_DATA_WORD :
                  (lane == LANE_LO)   ? T_DATA_BYTE : T_DATA_ODD;
      4'h9: tgt = (lane == LANE_WORD) ? T_DATA_WORD : T_DATA_ODD;
      4'h1, 4'hD: tgt = T_ERRFEAT;
      4'h2: tgt = T_COUNT;
      4'h3: tgt = T_SECTOR;
      4'h4: tgt = T_CYL_LO;
      4'h5: tgt = T_CYL_HI;
      4'h6: tgt = T_SELECT;
      4'h7: tgt = T_STATCMD;
      4'hE: tgt = T_ALTCTL;
      4'hF: tgt = T_DRVADDR;
      default: tgt = T_NONE;
    endcase

    if (!reg_n || lane == LANE_NONE) tgt = T_NONE;

    acc.tgt  = tgt;
    acc.lane = lane;
  end

endmodule

// File: rtl/mm_tf_edge.sv
module mm_tf_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_n,
  output logic active,
  output logic release_p
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[STAGES-1:0], strobe_n};
  end

  assign active    = ~sh[STAGES-1];
  assign release_p = sh[STAGES-1] & ~sh[STAGES];

  a_r11_single_release : assert property (@(posedge clk) disable iff (rst)
    release_p |=> !release_p);

endmodule

// File: rtl/mm_tf_dataport.sv
module mm_tf_dataport
  import mm_tf_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     rd_commit,
  input  logic                     wr_commit,
  input  tgt_e                     tgt,
  input  lane_e                    lane,
  input  logic [15:0]              wdata,
  output logic [15:0]              rd_word,
  output logic                     hi_turn,
  output logic [$clog2(DEPTH)-1:0] ptr_o
);
  localparam int PW = $clog2(DEPTH);

  logic [15:0] mem [DEPTH];
  logic [PW-1:0] ptr, ptr_nx;
  phase_e phase, phase_nx;
  logic xfer, is_data, wr_lo, wr_hi;
  logic [7:0] wbyte;

  assign xfer    = rd_commit | wr_commit;
  assign is_data = (tgt == T_DATA_WORD) || (tgt == T_DATA_BYTE) || (tgt == T_DATA_ODD);
  assign hi_turn = (phase == PH_LO_DONE);

  always_comb begin
    ptr_nx   = ptr;
    phase_nx = phase;
    wr_lo    = 1'b0;
    wr_hi    = 1'b0;
    wbyte    = (lane == LANE_HI) ? wdata[15:8] : wdata[7:0];
    if (xfer && is_data) begin
      case (tgt)
        T_DATA_WORD: begin
          wr_lo = 1'b1;
          wr_hi = 1'b1;
          ptr_nx   = ptr + 1'b1;
          phase_nx = PH_NONE;
        end
        T_DATA_BYTE: begin
          if (phase == PH_NONE) begin
            wr_lo    = 1'b1;
            phase_nx = PH_LO_DONE;
          end else begin
            wr_hi    = (phase == PH_LO_DONE);
            wr_lo    = (phase == PH_HI_DONE);
            ptr_nx   = ptr + 1'b1;
            phase_nx = PH_NONE;
          end
        end
        default: begin
          wr_hi = 1'b1;
          if (phase == PH_NONE) phase_nx = PH_HI_DONE;
          else begin
            ptr_nx   = ptr + 1'b1;
            phase_nx = PH_NONE;
          end
        end
      endcase
    end
    if (!wr_commit) begin
      wr_lo = 1'b0;
      wr_hi = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ptr   <= '0;
      phase <= PH_NONE;
    end else begin
      ptr   <= ptr_nx;
      phase <= phase_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (tgt == T_DATA_WORD) begin
      if (wr_lo) mem[ptr] <= wdata;
    end else begin
      if (wr_lo) mem[ptr][7:0]  <= wbyte;
      if (wr_hi) mem[ptr][15:8] <= wbyte;
    end
  end

  assign rd_word = mem[ptr];
  assign ptr_o   = ptr;

  a_r5_word_step : assert property (@(posedge clk) disable iff (rst)
    (xfer && tgt == T_DATA_WORD && !clr) |=> ptr == $past(ptr) + 1'b1);

  a_r6_pair_step : assert property (@(posedge clk) disable iff (rst)
    (xfer && tgt == T_DATA_BYTE && phase == PH_LO_DONE && !clr)
      |=> (ptr == $past(ptr) + 1'b1) && phase == PH_NONE);

  a_r10_rewind : assert property (@(posedge clk) disable iff (rst)
    clr |=> (ptr == '0) && phase == PH_NONE);

endmodule

// File: rtl/mm_taskfile_port.sv
module mm_taskfile_port
  import mm_tf_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int DEPTH       = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce1_n,
  input  logic              ce2_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  input  logic [7:0]        err_in,
  input  logic [7:0]        status_in,
  input  logic [7:0]        drive_in,
  output logic [7:0]        tf_features,
  output logic [7:0]        tf_count,
  output logic [7:0]        tf_sector,
  output logic [7:0]        tf_cyl_lo,
  output logic [7:0]        tf_cyl_hi,
  output logic [7:0]        tf_select,
  output logic [7:0]        tf_devctl,
  output logic [7:0]        cmd_code,
  output logic              cmd_strobe
);
  localparam int PW = $clog2(DEPTH);

  acc_t acc_live, acc_q;
  logic [15:0] wdata_q, rd_word;
  logic we_act, we_rel, oe_act, oe_rel;
  logic wr_commit, rd_commit, clr, hi_turn;
  logic [PW-1:0] ptr;
  logic [7:0] wbyte, rbyte;

  mm_tf_decode #(.ADDR_W(ADDR_W)) u_dec (
    .reg_n(reg_n), .addr(addr), .ce1_n(ce1_n), .ce2_n(ce2_n), .acc(acc_live)
  );

  mm_tf_edge #(.STAGES(SYNC_STAGES)) u_we_sync (
    .clk(clk), .rst(rst), .strobe_n(we_n), .active(we_act), .release_p(we_rel)
  );

  mm_tf_edge #(.STAGES(SYNC_STAGES)) u_oe_sync (
    .clk(clk), .rst(rst), .strobe_n(oe_n), .active(oe_act), .release_p(oe_rel)
  );

  // hold the access description while the strobe is seen low
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '{tgt: T_NONE, lane: LANE_NONE};
      wdata_q <= '0;
    end else if (we_act || oe_act) begin
      acc_q   <= acc_live;
      wdata_q <= wdata;
    end
  end

  assign wr_commit = we_rel;
  assign rd_commit = oe_rel & ~we_rel;
  assign clr       = wr_commit && (acc_q.tgt == T_STATCMD);
  assign wbyte     = (acc_q.lane == LANE_HI) ? wdata_q[15:8] : wdata_q[7:0];

  mm_tf_dataport #(.DEPTH(DEPTH)) u_data (
    .clk(clk), .rst(rst), .clr(clr), .rd_commit(rd_commit), .wr_commit(wr_commit),
    .tgt(acc_q.tgt), .lane(acc_q.lane), .wdata(wdata_q),
    .rd_word(rd_word), .hi_turn(hi_turn), .ptr_o(ptr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tf_features <= '0;
      tf_count    <= '0;
      tf_sector   <= '0;
      tf_cyl_lo   <= '0;
      tf_cyl_hi   <= '0;
      tf_select   <= '0;
      tf_devctl   <= '0;
      cmd_code    <= '0;
      cmd_strobe  <= 1'b0;
    end else begin
      cmd_strobe <= 1'b0;
      if (wr_commit) begin
        case (acc_q.tgt)
          T_ERRFEAT: tf_features <= wbyte;
          T_COUNT:   tf_count    <= wbyte;
          T_SECTOR:  tf_sector   <= wbyte;
          T_CYL_LO:  tf_cyl_lo   <= wbyte;
          T_CYL_HI:  tf_cyl_hi   <= wbyte;
          T_SELECT:  tf_select   <= wbyte;
          T_ALTCTL:  tf_devctl   <= wbyte;
          T_STATCMD: begin
            cmd_code   <= wbyte;
            cmd_strobe <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (acc_live.tgt)
      T_DATA_BYTE: rbyte = hi_turn ? rd_word[15:8] : rd_word[7:0];
      T_DATA_ODD:  rbyte = rd_word[15:8];
      T_ERRFEAT:   rbyte = err_in;
      T_COUNT:     rbyte = tf_count;
      T_SECTOR:    rbyte = tf_sector;
      T_CYL_LO:    rbyte = tf_cyl_lo;
      T_CYL_HI:    rbyte = tf_cyl_hi;
      T_SELECT:    rbyte = tf_select;
      T_STATCMD, T_ALTCTL: rbyte = status_in;
      T_DRVADDR:   rbyte = drive_in;
      default:     rbyte = 8'h00;
    endcase
    if (oe_n || acc_live.tgt == T_NONE)    rdata = 16'h0000;
    else if (acc_live.tgt == T_DATA_WORD)  rdata = rd_word;
    else if (acc_live.lane == LANE_HI)     rdata = {rbyte, 8'h00};
    else                                   rdata = {8'h00, rbyte};
  end

  a_r3_drvaddr_readonly : assert property (@(posedge clk) disable iff (rst)
    (wr_commit && acc_q.tgt == T_DRVADDR)
      |=> $stable({tf_features, tf_count, tf_sector, tf_cyl_lo, tf_cyl_hi,
                   tf_select, tf_devctl, cmd_code}) && !cmd_strobe);

  a_r4_errfeat_no_step : assert property (@(posedge clk) disable iff (rst)
    ((wr_commit || rd_commit) && acc_q.tgt == T_ERRFEAT) |=> $stable(ptr));

  a_r2_deselect_quiet : assert property (@(posedge clk) disable iff (rst)
    (wr_commit && acc_q.tgt == T_NONE)
      |=> $stable({tf_features, tf_count, tf_sector, tf_cyl_lo, tf_cyl_hi,
                   tf_select, tf_devctl, cmd_code, ptr}));

endmodule

// File: tb/mm_taskfile_port_bench.sv
module mm_taskfile_port_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_n = 1'b1;
  logic [10:0] addr = '0;
  logic ce1_n = 1'b1, ce2_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [7:0] err_in = 8'hE5, status_in = 8'h50, drive_in = 8'hD3;
  logic [7:0] tf_features, tf_count, tf_sector, tf_cyl_lo, tf_cyl_hi;
  logic [7:0] tf_select, tf_devctl, cmd_code;
  logic cmd_strobe;

  int tests = 0;
  int fails = 0;
  int pulses = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  always @(posedge clk) if (cmd_strobe) pulses++;

  mm_taskfile_port u_mm_taskfile_port (
    .clk(clk), .rst(rst), .reg_n(reg_n), .addr(addr), .ce1_n(ce1_n), .ce2_n(ce2_n),
    .oe_n(oe_n), .we_n(we_n), .wdata(wdata), .rdata(rdata),
    .err_in(err_in), .status_in(status_in), .drive_in(drive_in),
    .tf_features(tf_features), .tf_count(tf_count), .tf_sector(tf_sector),
    .tf_cyl_lo(tf_cyl_lo), .tf_cyl_hi(tf_cyl_hi), .tf_select(tf_select),
    .tf_devctl(tf_devctl), .cmd_code(cmd_code), .cmd_strobe(cmd_strobe)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic c1, input logic c2, input logic [15:0] d);
    @(negedge clk);
    addr = a; ce1_n = c1; ce2_n = c2; wdata = d; we_n = 1'b0;
    repeat (5) @(negedge clk);
    we_n = 1'b1;
    repeat (6) @(negedge clk);
    ce1_n = 1'b1; ce2_n = 1'b1;
  endtask

  task automatic rd(input logic [10:0] a, input logic c1, input logic c2, output logic [15:0] d);
    @(negedge clk);
    addr = a; ce1_n = c1; ce2_n = c2; oe_n = 1'b0;
    repeat (4) @(negedge clk);
    d = rdata;
    oe_n = 1'b1;
    repeat (6) @(negedge clk);
    ce1_n = 1'b1; ce2_n = 1'b1;
  endtask

  task automatic rewind();
    wr(11'h007, 1'b0, 1'b1, 16'h00C0);
  endtask

  task automatic t_reset();
    check("R1 rdata idle", rdata, 16'h0000);
    check("R1 regs", {tf_count, tf_features}, 16'h0000);
    check("R1 cmd", {cmd_code, 7'b0, cmd_strobe}, 16'h0000);
  endtask

  task automatic t_taskfile();
    logic [15:0] d;
    wr(11'h002, 1'b0, 1'b1, 16'h0012);
    rd(11'h002, 1'b0, 1'b1, d);
    check("R3 count low lane", d, 16'h0012);
    rd(11'h002, 1'b1, 1'b0, d);
    check("R3 count high lane", d, 16'h1200);
    wr(11'h3F5, 1'b1, 1'b0, 16'h7700);
    check("R2 ignored upper bits write", {8'h00, tf_cyl_hi}, 16'h0077);
    rd(11'h005, 1'b0, 1'b1, d);
    check("R2 read back plain offset", d, 16'h0077);
    wr(11'h003, 1'b0, 1'b1, 16'h0033);
    wr(11'h004, 1'b0, 1'b1, 16'h0044);
    wr(11'h006, 1'b0, 1'b1, 16'h00A6);
    check("R3 sector/cyl_lo", {tf_sector, tf_cyl_lo}, 16'h3344);
    check("R3 select", {8'h00, tf_select}, 16'h00A6);
    wr(11'h001, 1'b0, 1'b1, 16'h0011);
    check("R3 features at 1", {8'h00, tf_features}, 16'h0011);
    wr(11'h00D, 1'b0, 1'b1, 16'h00DD);
    check("R3 features at D", {8'h00, tf_features}, 16'h00DD);
    rd(11'h001, 1'b0, 1'b1, d);
    check("R3 error at 1", d, 16'h00E5);
    rd(11'h00D, 1'b1, 1'b0, d);
    check("R3 error at D high lane", d, 16'hE500);
    rd(11'h007, 1'b0, 1'b1, d);
    check("R3 status at 7", d, 16'h0050);
    rd(11'h00E, 1'b0, 1'b1, d);
    check("R3 alt status at E", d, 16'h0050);
    wr(11'h00E, 1'b0, 1'b1, 16'h0006);
    check("R3 device control", {8'h00, tf_devctl}, 16'h0006);
    wr(11'h00F, 1'b0, 1'b1, 16'h00FF);
    check("R3 drive addr write ignored",
          {tf_devctl, tf_features}, 16'h06DD);
    rd(11'h00F, 1'b0, 1'b1, d);
    check("R3 drive addr read", d, 16'h00D3);
    pulses = 0;
    wr(11'h007, 1'b0, 1'b1, 16'h0020);
    check("R3 command code", {8'h00, cmd_code}, 16'h0020);
    check("R3 one strobe", 16'(pulses), 16'd1);
  endtask

  task automatic t_regspace();
    logic [15:0] d;
    reg_n = 1'b0;
    wr(11'h002, 1'b0, 1'b1, 16'h00EE);
    rd(11'h002, 1'b0, 1'b1, d);
    check("R2 attribute read zero", d, 16'h0000);
    reg_n = 1'b1;
    check("R2 attribute write ignored", {8'h00, tf_count}, 16'h0012);
  endtask

  task automatic t_words();
    logic [15:0] d;
    rewind();
    wr(11'h000, 1'b0, 1'b0, 16'hBBAA);
    wr(11'h008, 1'b0, 1'b0, 16'hDDCC);
    wr(11'h009, 1'b0, 1'b0, 16'h2211);
    wr(11'h400, 1'b0, 1'b0, 16'h4433);
    rewind();
    rd(11'h000, 1'b0, 1'b0, d); check("R5 word 0", d, 16'hBBAA);
    rd(11'h009, 1'b0, 1'b0, d); check("R5 word 1 via 9", d, 16'hDDCC);
    rd(11'h008, 1'b0, 1'b0, d); check("R5 word 2 via 8", d, 16'h2211);
    rd(11'h7FE, 1'b0, 1'b0, d); check("R9 word 3 via window", d, 16'h4433);
  endtask

  task automatic t_byte_pairs();
    logic [15:0] d;
    rewind();
    wr(11'h008, 1'b0, 1'b1, 16'h0061);
    wr(11'h008, 1'b0, 1'b1, 16'h0062);
    wr(11'h000, 1'b0, 1'b1, 16'h0063);
    wr(11'h000, 1'b0, 1'b1, 16'h0064);
    rewind();
    rd(11'h000, 1'b0, 1'b0, d); check("R6 byte writes pack word 0", d, 16'h6261);
    rd(11'h000, 1'b0, 1'b0, d); check("R6 byte writes pack word 1", d, 16'h6463);
    rewind();
    rd(11'h000, 1'b0, 1'b1, d); check("R6 first byte low", d, 16'h0061);
    rd(11'h000, 1'b0, 1'b1, d); check("R6 second byte high", d, 16'h0062);
    rd(11'h008, 1'b0, 1'b1, d); check("R6 next word low", d, 16'h0063);
  endtask

  task automatic t_odd_offset();
    logic [15:0] d;
    rewind();
    rd(11'h008, 1'b0, 1'b1, d); check("R7 8 then 9: low", d, 16'h0061);
    rd(11'h009, 1'b0, 1'b1, d); check("R7 8 then 9: high", d, 16'h0062);
    rd(11'h008, 1'b0, 1'b1, d); check("R7 advanced after pair", d, 16'h0063);
    rewind();
    rd(11'h009, 1'b0, 1'b1, d); check("R7 9 then 8: high first", d, 16'h0062);
    rd(11'h008, 1'b0, 1'b1, d); check("R7 9 then 8: low same word", d, 16'h0061);
    rd(11'h009, 1'b1, 1'b0, d); check("R11 high byte on upper lane", d, 16'h6400);
    rewind();
    rd(11'h009, 1'b0, 1'b1, d); check("R8 repeat 9 first", d, 16'h0062);
    rd(11'h009, 1'b0, 1'b1, d); check("R8 repeat 9 same word", d, 16'h0062);
    rd(11'h008, 1'b0, 1'b1, d); check("R8 advanced after second", d, 16'h0063);
  endtask

  task automatic t_lane_zero();
    logic [15:0] d;
    rewind();
    wr(11'h000, 1'b1, 1'b0, 16'h5A00);
    check("R4 features via offset 0 high lane", {8'h00, tf_features}, 16'h005A);
    rd(11'h000, 1'b1, 1'b0, d);
    check("R4 error via offset 0 high lane", d, 16'hE500);
    rd(11'h000, 1'b0, 1'b0, d);
    check("R4 buffer and pointer untouched", d, 16'h6261);
  endtask

  task automatic t_window();
    logic [15:0] d;
    rewind();
    rd(11'h400, 1'b0, 1'b1, d); check("R9 even addr low", d, 16'h0061);
    rd(11'h401, 1'b0, 1'b1, d); check("R9 odd addr high", d, 16'h0062);
    rd(11'h402, 1'b0, 1'b1, d); check("R9 next even addr", d, 16'h0063);
  endtask

  task automatic t_rewind_mid();
    logic [15:0] d;
    rewind();
    rd(11'h008, 1'b0, 1'b1, d);
    rewind();
    rd(11'h008, 1'b0, 1'b1, d); check("R10 phase back to low byte", d, 16'h0061);
  endtask

  task automatic t_commit_timing();
    @(negedge clk);
    addr = 11'h002; ce1_n = 1'b0; ce2_n = 1'b1; wdata = 16'h0099; we_n = 1'b0;
    repeat (5) @(negedge clk);
    check("R11 no write while strobe low", {8'h00, tf_count}, 16'h0012);
    we_n = 1'b1;
    repeat (6) @(negedge clk);
    ce1_n = 1'b1;
    check("R11 write after release", {8'h00, tf_count}, 16'h0099);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_taskfile();
    t_regspace();
    t_words();
    t_byte_pairs();
    t_odd_offset();
    t_lane_zero();
    t_window();
    t_rewind_mid();
    t_commit_timing();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule